// File: doc/BRIEF.md
# I/O Channel Flag and Interrupt Controller

This block keeps the per-channel handshake state for a processor's input/output system. Each of `NUM_CH` channels, addressed by a select code, owns a control bit (device connected and allowed to interrupt) and a flag bit (device finished a transfer). The block also holds two global bits: the interrupt-system enable and the arithmetic overflow bit. The processor issues one I/O operation per cycle as a strobe carrying an operation code, a select code, an optional clear-flag request and the accumulator value. The block answers with a skip request, read-back data or a one-hot write strobe toward a device buffer.

Select codes 0 and 1 do not address ordinary channels. Code 0 addresses the interrupt system and the clear-all-control function. Code 1 addresses the overflow bit and the switch register. Devices pulse a per-channel done input that sets the flag. When interrupts are enabled, the lowest-numbered channel at or above `FIRST_IRQ_CH` whose control and flag bits are both set raises an interrupt request and drives its number as the vector. A hold-off input suppresses the request, for example while an indirect jump is completing.

All outputs are registered. Data, skip and write-strobe results appear one cycle after the operation is sampled. The interrupt request and vector reflect the channel state one cycle after that state changes.

Top module: `io_flag_irq_ctrl`

## Requirements
- R1: After a synchronous reset, every control bit, every flag, the interrupt enable and the overflow bit are 0, and `irq_req`, `skip_req`, `rd_valid` and `out_we` are 0.
- R2: Op code 0 (set control) sets the control bit of a select code of 2 or more. Op code 1 (clear control) clears it, and with select code 0 clears every control bit. Op codes 0 and 1 with select code 1, and op code 0 with select code 0, change nothing. `ctrl_out` shows the control bits on the cycle after the operation.
- R3: A high `dev_done[i]` sets the flag of channel i (i of 2 or more) whatever its control bit is. Op code 2 (set flag) sets the addressed channel flag and op code 3 (clear flag) clears it. Channels 0 and 1 have no flag, and their flag always reads as clear.
- R4: Op code 2 with select code 0 enables the interrupt system. Op code 3 with select code 0 disables it.
- R5: Op code 2 with select code 1 sets the overflow bit and op code 3 with select code 1 clears it. `ovf_o` shows the bit on the cycle after the operation.
- R6: Op code 4 requests a skip when the tested bit is clear, and op code 5 requests a skip when it is set. The tested bit is the channel flag, or the overflow bit for select code 1. `skip_req` is high for the one cycle after the operation.
- R7: Op code 6 (input) returns the buffer of the addressed channel, or `switch_in` for select code 1. Op code 7 (merge) returns the bitwise OR of that value and `acc_in`. `rd_valid` and `rd_data` appear on the cycle after the operation.
- R8: Op code 8 (output) pulses `out_we` one-hot for the addressed channel, with `out_data` equal to `acc_in`, for select codes of 2 or more. For select codes 0 and 1 no strobe is given.
- R9: For op codes other than 2 and 3, a high `op_clr` clears the addressed channel flag, or the overflow bit for select code 1, after the operation. A skip test or read in the same operation uses the old value.
- R10: If `dev_done[i]` and a clear of flag i (op code 3 or the clear option) occur in the same cycle, the flag ends up set.
- R11: `irq_req` is high when the interrupt system is enabled and some channel numbered `FIRST_IRQ_CH` (8) or above has both its control and flag bits set. `irq_vec` then equals the lowest such channel number. Both outputs follow the state with one cycle of delay.
- R12: While `irq_inhibit` is high in a cycle, `irq_req` is low in the following cycle.
- R13: Op codes 9 to 15 change no state and produce no skip, read or write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | I/O operation strobe |
| op_code | input | 4 | Operation code |
| op_sel | input | SEL_W (6) | Select code |
| op_clr | input | 1 | Clear-flag option |
| acc_in | input | DATA_W (16) | Accumulator value for merge and output |
| dev_done | input | NUM_CH (64) | Per-channel transfer-complete pulses |
| dev_buf | input | NUM_CH*DATA_W (1024) | Device buffers, channel i at bits i*DATA_W upward |
| switch_in | input | DATA_W (16) | Switch register value |
| irq_inhibit | input | 1 | Interrupt hold-off |
| rd_data | output | DATA_W (16) | Input or merge result |
| rd_valid | output | 1 | rd_data valid |
| skip_req | output | 1 | Skip the next instruction |
| out_data | output | DATA_W (16) | Data for a device buffer write |
| out_we | output | NUM_CH (64) | One-hot buffer write strobe |
| ctrl_out | output | NUM_CH (64) | Control bits |
| ovf_o | output | 1 | Overflow bit |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | SEL_W (6) | Winning channel number |

## Verification
The hardest situation to reach is a shift of the interrupt winner among many pending channels. This needs the control and flag state of dozens of channels built up together. The bench enables interrupts, connects every channel, and raises flags from the top channel down to channel 2, checking the vector after each one. It then clears the flags upward and checks that the winner moves to the next higher pending channel, and that channels below 8 never win. The same-cycle race between a device pulse and a flag clear is driven directly by pairing the pulse with the clear operation in one strobe.

// File: rtl/io_ctl_pkg.sv
package io_ctl_pkg;
  typedef enum logic [3:0] {
    OP_SET_CTL   = 4'd0,
    OP_CLR_CTL   = 4'd1,
    OP_SET_FLG   = 4'd2,
    OP_CLR_FLG   = 4'd3,
    OP_SKIP_FCLR = 4'd4,
    OP_SKIP_FSET = 4'd5,
    OP_LOAD      = 4'd6,
    OP_MERGE     = 4'd7,
    OP_STORE     = 4'd8
  } io_op_e;

  localparam logic [3:0] OP_LAST = 4'd8;
  localparam int SEL_SYS = 0;
  localparam int SEL_OVF = 1;
endpackage

// File: rtl/io_chan_bits.sv
module io_chan_bits #(
  parameter int NUM_CH = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] set_ctl,
  input  logic [NUM_CH-1:0] clr_ctl,
  input  logic              clr_ctl_all,
  input  logic [NUM_CH-1:0] set_flg,
  input  logic [NUM_CH-1:0] clr_flg,
  input  logic [NUM_CH-1:0] dev_done,
  output logic [NUM_CH-1:0] ctrl,
  output logic [NUM_CH-1:0] flag
);
  localparam int NUM_SYS = 2;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    if (i < NUM_SYS) begin : g_sys
      logic unused_sys;
      assign unused_sys = set_ctl[i] ^ clr_ctl[i] ^ set_flg[i] ^ clr_flg[i] ^ dev_done[i];
      assign ctrl[i] = 1'b0;
      assign flag[i] = 1'b0;
    end else begin : g_dev
      logic ctl_q;
      logic flg_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          ctl_q <= 1'b0;
        end else if (clr_ctl_all || clr_ctl[i]) begin
          ctl_q <= 1'b0;
        end else if (set_ctl[i]) begin
          ctl_q <= 1'b1;
        end
      end
      // a device pulse outranks any clear in the same cycle
      always_ff @(posedge clk) begin
        if (rst) begin
          flg_q <= 1'b0;
        end else if (dev_done[i] || set_flg[i]) begin
          flg_q <= 1'b1;
        end else if (clr_flg[i]) begin
          flg_q <= 1'b0;
        end
      end
      assign ctrl[i] = ctl_q;
      assign flag[i] = flg_q;
    end
  end
endmodule

// File: rtl/io_prio_enc.sv
module io_prio_enc #(
  parameter int N = 64,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = W'(i);
      end
    end
  end
endmodule

// File: rtl/io_data_mux.sv
module io_data_mux #(
  parameter int NUM_CH = 64,
  parameter int DATA_W = 16,
  localparam int SEL_W = $clog2(NUM_CH)
) (
  input  logic [SEL_W-1:0]         sel,
  input  logic [NUM_CH*DATA_W-1:0] dev_buf,
  input  logic [DATA_W-1:0]        switch_in,
  input  logic [DATA_W-1:0]        acc_in,
  input  logic                     merge,
  output logic [DATA_W-1:0]        data
);
  logic [DATA_W-1:0] buf_arr [NUM_CH];
  logic [DATA_W-1:0] src;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_unpack
    assign buf_arr[i] = dev_buf[i*DATA_W +: DATA_W];
  end

  always_comb begin
    src  = (sel == SEL_W'(io_ctl_pkg::SEL_OVF)) ? switch_in : buf_arr[sel];
    data = merge ? (src | acc_in) : src;
  end
endmodule

// File: rtl/io_flag_irq_ctrl.sv
module io_flag_irq_ctrl #(
  parameter int NUM_CH       = 64,
  parameter int DATA_W       = 16,
  parameter int FIRST_IRQ_CH = 8,
  localparam int SEL_W = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     op_valid,
  input  logic [3:0]               op_code,
  input  logic [SEL_W-1:0]         op_sel,
  input  logic                     op_clr,
  input  logic [DATA_W-1:0]        acc_in,
  input  logic [NUM_CH-1:0]        dev_done,
  input  logic [NUM_CH*DATA_W-1:0] dev_buf,
  input  logic [DATA_W-1:0]        switch_in,
  input  logic                     irq_inhibit,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     rd_valid,
  output logic                     skip_req,
  output logic [DATA_W-1:0]        out_data,
  output logic [NUM_CH-1:0]        out_we,
  output logic [NUM_CH-1:0]        ctrl_out,
  output logic                     ovf_o,
  output logic                     irq_req,
  output logic [SEL_W-1:0]         irq_vec
);
  import io_ctl_pkg::*;

  localparam logic [NUM_CH-1:0] ONE_CH = NUM_CH'(1);

  io_op_e            op;
  logic              op_ok;
  logic              sel_sys, sel_ovf, sel_dev;
  logic [NUM_CH-1:0] sel_1h, dev_1h;
  logic [NUM_CH-1:0] set_ctl, clr_ctl, set_flg, clr_flg;
  logic              clr_all, opt_clr;
  logic [NUM_CH-1:0] ctrl, flag, irq_mask, pend;
  logic              test_bit, skip_d;
  logic              ien_q, ovf_q;
  logic              pend_any;
  logic [SEL_W-1:0]  pend_idx;
  logic [DATA_W-1:0] rd_d;
  logic              is_read, is_store;

  assign op    = io_op_e'(op_code);
  assign op_ok = op_valid && (op_code <= OP_LAST);

  assign sel_sys = (op_sel == SEL_W'(SEL_SYS));
  assign sel_ovf = (op_sel == SEL_W'(SEL_OVF));
  assign sel_dev = !sel_sys && !sel_ovf;
  assign sel_1h  = ONE_CH << op_sel;
  assign dev_1h  = sel_dev ? sel_1h : '0;

  assign opt_clr = op_ok && op_clr && (op != OP_SET_FLG) && (op != OP_CLR_FLG);
  assign set_ctl = (op_ok && op == OP_SET_CTL) ? dev_1h : '0;
  assign clr_ctl = (op_ok && op == OP_CLR_CTL) ? dev_1h : '0;
  assign clr_all = op_ok && (op == OP_CLR_CTL) && sel_sys;
  assign set_flg = (op_ok && op == OP_SET_FLG) ? dev_1h : '0;
  assign clr_flg = ((op_ok && op == OP_CLR_FLG) || opt_clr) ? dev_1h : '0;

  io_chan_bits #(.NUM_CH(NUM_CH)) u_bits (
    .clk(clk), .rst(rst),
    .set_ctl(set_ctl), .clr_ctl(clr_ctl), .clr_ctl_all(clr_all),
    .set_flg(set_flg), .clr_flg(clr_flg), .dev_done(dev_done),
    .ctrl(ctrl), .flag(flag)
  );

  // global bits at select codes 0 and 1
  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q <= 1'b0;
    end else if (op_ok && sel_sys) begin
      if (op == OP_SET_FLG) ien_q <= 1'b1;
      else if (op == OP_CLR_FLG) ien_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q <= 1'b0;
    end else if (op_ok && sel_ovf) begin
      if (op == OP_SET_FLG) ovf_q <= 1'b1;
      else if (op == OP_CLR_FLG || op_clr) ovf_q <= 1'b0;
    end
  end

  // skip decision on the state before the operation
  always_comb begin
    test_bit = sel_ovf ? ovf_q : |(flag & sel_1h);
    skip_d   = op_ok && (((op == OP_SKIP_FCLR) && !test_bit) ||
                         ((op == OP_SKIP_FSET) && test_bit));
  end

  assign is_read  = op_ok && (op == OP_LOAD || op == OP_MERGE);
  assign is_store = op_ok && (op == OP_STORE);

  io_data_mux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_mux (
    .sel(op_sel), .dev_buf(dev_buf), .switch_in(switch_in),
    .acc_in(acc_in), .merge(op == OP_MERGE), .data(rd_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      skip_req <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      out_we   <= '0;
      out_data <= '0;
    end else begin
      skip_req <= skip_d;
      rd_valid <= is_read;
      rd_data  <= is_read ? rd_d : '0;
      out_we   <= is_store ? dev_1h : '0;
      if (is_store) out_data <= acc_in;
    end
  end

  // interrupt arbitration: lowest eligible channel wins
  for (genvar i = 0; i < NUM_CH; i++) begin : g_mask
    assign irq_mask[i] = (i >= FIRST_IRQ_CH);
  end
  assign pend = ctrl & flag & irq_mask;

  io_prio_enc #(.N(NUM_CH)) u_prio (.req(pend), .any(pend_any), .idx(pend_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
    end else begin
      irq_req <= ien_q && pend_any && !irq_inhibit;
      irq_vec <= pend_any ? pend_idx : '0;
    end
  end

  assign ctrl_out = ctrl;
  assign ovf_o    = ovf_q;
endmodule

// File: rtl/io_flag_irq_ctrl_chk.sv
module io_flag_irq_ctrl_chk #(
  parameter int NUM_CH       = 64,
  parameter int FIRST_IRQ_CH = 8,
  localparam int SEL_W = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [3:0]        op_code,
  input logic [SEL_W-1:0]  op_sel,
  input logic [NUM_CH-1:0] out_we,
  input logic [NUM_CH-1:0] ctrl_out,
  input logic              ovf_o,
  input logic              skip_req,
  input logic              irq_inhibit,
  input logic              irq_req,
  input logic [SEL_W-1:0]  irq_vec
);
  logic [NUM_CH-1:0] ctrl_d;
  always_ff @(posedge clk) ctrl_d <= ctrl_out;

  p_clr_all_r2: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd1 && op_sel == '0) |=> (ctrl_out == '0));

  p_sel1_ctl_noop_r2: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code <= 4'd1 && op_sel == SEL_W'(1)) |=> $stable(ctrl_out));

  p_ovf_set_r5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd2 && op_sel == SEL_W'(1)) |=> ovf_o);

  p_ovf_clr_r5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd3 && op_sel == SEL_W'(1)) |=> !ovf_o);

  p_skip_src_r6: assert property (@(posedge clk) disable iff (rst)
    skip_req |-> $past(op_valid && (op_code == 4'd4 || op_code == 4'd5)));

  p_we_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(out_we));

  p_we_sys_r8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel <= SEL_W'(1)) |=> (out_we == '0));

  p_vec_owner_r11: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (ctrl_d[irq_vec] && (int'(irq_vec) >= FIRST_IRQ_CH)));

  p_inhibit_r12: assert property (@(posedge clk) disable iff (rst)
    $past(irq_inhibit) |-> !irq_req);

  p_bad_op_r13: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code > 4'd8) |=> (!skip_req && out_we == '0 && $stable(ctrl_out)));
endmodule

bind io_flag_irq_ctrl io_flag_irq_ctrl_chk #(
  .NUM_CH(NUM_CH), .FIRST_IRQ_CH(FIRST_IRQ_CH)
) chk_i (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .op_sel(op_sel),
  .out_we(out_we), .ctrl_out(ctrl_out), .ovf_o(ovf_o), .skip_req(skip_req),
  .irq_inhibit(irq_inhibit), .irq_req(irq_req), .irq_vec(irq_vec)
);

// File: tb/io_flag_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module io_flag_irq_ctrl_tb_top;
  localparam int NCH = 64;
  localparam int DW  = 16;
  localparam int FIRST = 8;
  localparam int SW  = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_valid = 1'b0;
  logic [3:0] op_code = '0;
  logic [SW-1:0] op_sel = '0;
  logic op_clr = 1'b0;
  logic [DW-1:0] acc_in = '0;
  logic [NCH-1:0] dev_done = '0;
  logic [NCH*DW-1:0] dev_buf;
  logic [DW-1:0] switch_in = 16'hC3A5;
  logic irq_inhibit = 1'b0;
  logic [DW-1:0] rd_data, out_data;
  logic rd_valid, skip_req, ovf_o, irq_req;
  logic [NCH-1:0] out_we, ctrl_out;
  logic [SW-1:0] irq_vec;

  always #4 clk = ~clk;

  io_flag_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .op_sel(op_sel),
    .op_clr(op_clr), .acc_in(acc_in), .dev_done(dev_done), .dev_buf(dev_buf),
    .switch_in(switch_in), .irq_inhibit(irq_inhibit), .rd_data(rd_data),
    .rd_valid(rd_valid), .skip_req(skip_req), .out_data(out_data), .out_we(out_we),
    .ctrl_out(ctrl_out), .ovf_o(ovf_o), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [NCH-1:0] ctrl_m = '0, flag_m = '0;
  bit ien_m = 0, ovf_m = 0;

  function automatic logic [DW-1:0] bufval(int ch);
    return DW'((ch * 613) ^ 16'h5A3C);
  endfunction

  initial begin
    for (int i = 0; i < NCH; i++) dev_buf[i*DW +: DW] = bufval(i);
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_op(int op, int sel, bit clr, logic [DW-1:0] acc, logic [NCH-1:0] done);
    bit ok, sys, ov, dv, tb, e_skip, e_rv;
    logic [DW-1:0] src, e_rd;
    logic [NCH-1:0] e_we;
    ok = (op <= 8); sys = (sel == 0); ov = (sel == 1); dv = (sel >= 2);
    tb = ov ? ovf_m : (dv ? flag_m[sel] : 1'b0);
    e_skip = ok && ((op == 4 && !tb) || (op == 5 && tb));
    e_rv = ok && (op == 6 || op == 7);
    src = ov ? switch_in : bufval(sel);
    e_rd = (op == 7) ? (src | acc) : src;
    e_we = (ok && op == 8 && dv) ? (NCH'(1) << sel) : '0;
    @(negedge clk);
    op_valid = 1'b1; op_code = 4'(op); op_sel = SW'(sel); op_clr = clr;
    acc_in = acc; dev_done = done;
    @(posedge clk); #2;
    op_valid = 1'b0; op_clr = 1'b0; dev_done = '0;
    if (ok) begin
      if (dv) begin
        if (op == 0) ctrl_m[sel] = 1'b1;
        if (op == 1) ctrl_m[sel] = 1'b0;
        if (op == 2) flag_m[sel] = 1'b1;
        if (op == 3 || (clr && op != 2)) flag_m[sel] = 1'b0;
      end
      if (sys && op == 1) ctrl_m = '0;
      if (sys && op == 2) ien_m = 1;
      if (sys && op == 3) ien_m = 0;
      if (ov && op == 2) ovf_m = 1;
      else if (ov && (op == 3 || clr)) ovf_m = 0;
    end
    flag_m = flag_m | (done & ~NCH'(3));
    check(ok ? "R6 skip" : "R13 skip", 64'(skip_req), 64'(e_skip));
    check("R7 rd_valid", 64'(rd_valid), 64'(e_rv));
    if (e_rv) check("R7 rd_data", 64'(rd_data), 64'(e_rd));
    check("R8 out_we", out_we, e_we);
    if (e_we != '0) check("R8 out_data", 64'(out_data), 64'(acc));
    check("R2 ctrl_out", ctrl_out, ctrl_m);
    check("R5 ovf_o", 64'(ovf_o), 64'(ovf_m));
  endtask

  task automatic chk_irq(bit inh);
    logic [NCH-1:0] p;
    bit e_req;
    int e_vec;
    p = ctrl_m & flag_m;
    e_vec = 0;
    for (int i = NCH - 1; i >= FIRST; i--) if (p[i]) e_vec = i;
    e_req = ien_m && !inh && (e_vec != 0);
    @(negedge clk); irq_inhibit = inh;
    @(posedge clk); #2; irq_inhibit = 1'b0;
    check(inh ? "R12 irq_req" : "R11 irq_req", 64'(irq_req), 64'(e_req));
    if (e_req) check("R11 irq_vec", 64'(irq_vec), 64'(e_vec));
  endtask

  // sweep helper: flag of each channel probed with both skip ops
  task automatic probe_flags();
    for (int s = 0; s < NCH; s++) begin
      do_op(5, s, 0, '0, '0);
      do_op(4, s, 0, '0, '0);
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #2;
    // R1 reset state
    check("R1 ctrl", ctrl_out, '0);
    check("R1 ovf", 64'(ovf_o), 0);
    check("R1 irq", 64'(irq_req), 0);
    check("R1 skip", 64'(skip_req), 0);
    check("R1 we", out_we, '0);
    check("R1 rv", 64'(rd_valid), 0);
    @(negedge clk); rst = 1'b0;

    probe_flags();                                   // R6 all clear
    for (int s = 0; s < NCH; s++) do_op(0, s, 0, '0, '0);   // R2 set control
    do_op(1, 1, 0, '0, '0);                          // R2 select 1 no effect
    do_op(1, 9, 0, '0, '0);                          // R2 single clear
    do_op(0, 9, 0, '0, '0);

    // R3 device pulses then clears
    for (int s = 0; s < NCH; s++) do_op(9, 0, 0, '0, NCH'(1) << s);
    probe_flags();
    for (int s = 2; s < NCH; s++) do_op(3, s, 0, '0, '0);
    probe_flags();

    // R11 winner descends then ascends
    do_op(2, 0, 0, '0, '0);                          // R4 enable
    for (int k = NCH - 1; k >= 2; k--) begin
      do_op(2, k, 0, '0, '0);
      chk_irq(0);
    end
    chk_irq(1);                                      // R12 hold-off
    chk_irq(0);
    for (int k = 2; k < NCH; k++) begin
      do_op(3, k, 0, '0, '0);
      chk_irq(0);
    end

    // R3 flag rises with control clear, no interrupt from it
    do_op(2, 30, 0, '0, '0);
    do_op(1, 20, 0, '0, '0);
    do_op(9, 0, 0, '0, NCH'(1) << 20);
    do_op(5, 20, 0, '0, '0);
    chk_irq(0);
    // R10 device pulse wins over clear
    do_op(3, 40, 0, '0, NCH'(1) << 40);
    do_op(5, 40, 0, '0, '0);
    do_op(6, 41, 1, '0, NCH'(1) << 41);
    do_op(5, 41, 0, '0, '0);
    // R2 clear all
    do_op(1, 0, 0, '0, '0);
    chk_irq(0);
    do_op(0, 0, 0, '0, '0);
    do_op(0, 30, 0, '0, '0);
    chk_irq(0);
    do_op(3, 0, 0, '0, '0);                          // R4 disable
    chk_irq(0);
    do_op(2, 0, 0, '0, '0);
    chk_irq(0);

    // R5 and R9 overflow with clear option
    do_op(2, 1, 0, '0, '0);
    do_op(5, 1, 1, '0, '0);
    do_op(5, 1, 0, '0, '0);
    do_op(2, 1, 0, '0, '0);
    do_op(4, 1, 0, '0, '0);
    do_op(6, 1, 1, '0, '0);
    do_op(3, 1, 0, '0, '0);

    // R7 R8 data sweeps
    for (int s = 0; s < NCH; s++) begin
      logic [DW-1:0] a;
      a = DW'((s * 4099) ^ 16'h0F0F);
      do_op(6, s, 0, a, '0);
      do_op(7, s, 0, a, '0);
      do_op(8, s, 0, a, '0);
    end
    switch_in = 16'h1248;
    do_op(7, 1, 0, 16'h8001, '0);

    // R9 clear option on channels
    do_op(2, 50, 0, '0, '0);
    do_op(6, 50, 1, '0, '0);
    do_op(4, 50, 0, '0, '0);
    do_op(2, 51, 0, '0, '0);
    do_op(5, 51, 1, '0, '0);
    do_op(5, 51, 0, '0, '0);
    do_op(2, 52, 0, '0, '0);
    do_op(3, 52, 1, '0, '0);
    do_op(2, 52, 1, '0, '0);
    do_op(5, 52, 0, '0, '0);

    // R13 unused op codes
    for (int c = 9; c < 16; c++) do_op(c, 52, 1, 16'hFFFF, '0);
    do_op(5, 52, 0, '0, '0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule